// File: doc/BRIEF.md
# Dithered Switching-Period Generator with External Sync

This block sets the switching cycle of a digital power-stage controller. A period counter runs off the system clock and emits a one-clock `cyc_start` pulse each time a new switching cycle begins. The nominal length of a cycle, in clocks, comes from a programmable count. The legal range of that count covers at least the 10:1 span a switching controller needs. A second one-clock pulse, `dmax_mark`, marks the point in each cycle where the main switch must be turned off at the latest, so it bounds the on-time.

To lower conducted and radiated emission peaks, the period can be modulated by a slow symmetric triangle. The triangle climbs and falls by one step at a time between two trip levels, and it advances only once every programmable number of cycle starts, so it repeats far more slowly than the switching rate. The depth input scales how far the triangle moves the period, up to roughly ±9.4 %.

The block can also follow an external sync signal that runs somewhat faster than the internal rate. A sync pulse counts only if it stays high long enough and arrives inside a window that corresponds to about 1.1x to 1.28x of the internal frequency. An accepted sync pulse ends the current cycle early. The turn-off marker stays at its position in clocks, so the largest duty fraction grows with the sync ratio.

Top module: `osc_dither_sync`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `cyc_start` and `dmax_mark` are both low. The first `cyc_start` comes P clocks after reset release, where P is the period computed with a dither value of zero.
- R2: With dither disabled and no sync, `cyc_start` pulses for exactly one clock every P clocks. P is `period_nom`, raised to a floor of 8 if it is smaller.
- R3: The period is sampled only at each cycle start. If `period_nom` changes in the middle of a cycle, that cycle keeps its length and the next cycle uses the new value.
- R4: The dither value is a signed integer. It starts at 0 and rises when dither is enabled. It moves by exactly 1 per step, turns down on reaching +16 and turns up on reaching -16. It steps on every (`dith_rate`+1)-th cycle start. While `dith_en` is low it is held at 0.
- R5: At each cycle start the next period is computed as N + floor(N·T·D / 2048). N is the nominal count after the floor of 8, T is the dither value before that start's step, and D is the effective depth. The result is clamped to at least 8 and at most 2^16-1.
- R6: A `dith_depth` above 12 acts as 12. This keeps the period swing within about ±9.4 %.
- R7: A sync pulse is recognised only if `sync_in` stays high for at least 10 consecutive clocks. Shorter pulses leave the period unchanged. A level held high produces only one event.
- R8: A recognised sync pulse whose input rose on the clock edge before cycle count d ends the cycle after e = d+12 clocks. The `cyc_start` pulse is issued in that clock, and the event counts as a cycle start for R3 to R5.
- R9: A sync event is accepted only when 25·P ≤ 32·e ≤ 29·P, where e is the number of clocks elapsed in the current cycle including the event clock. All other sync events are ignored.
- R10: `dmax_mark` pulses once per cycle, floor(P·23/32) clocks after `cyc_start`, where P is the internal period of that cycle. A sync-shortened cycle does not move it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_nom | input | 16 | Nominal period in clocks |
| dith_en | input | 1 | Dither enable |
| dith_depth | input | 4 | Dither depth, saturates at 12 |
| dith_rate | input | 8 | Cycle starts per dither step, minus one |
| sync_in | input | 1 | Asynchronous external sync |
| cyc_start | output | 1 | One-clock pulse at each cycle start |
| dmax_mark | output | 1 | One-clock pulse at the latest turn-off point |

## Verification
On every cycle the assertions hold the following invariants. The period counter stays below the latched period, and the latched period never drops under its floor. Each cycle start comes either from a wrap or from an accepted sync event. The dither value stays within its trip levels and moves by at most one per step. The turn-off marker lands strictly inside a cycle and never coincides with a cycle start. Several things are visible only in the bench's scenarios, which compare them against a reference model: the exact interval sequence under dither, the depth saturation, the mid-cycle period change, the sync width and timing window, and the marker position.

// File: rtl/osc_pkg.sv
`timescale 1ns/1ps
// Shared types for the switching-period generator.
// Assumes nothing beyond standard SystemVerilog.
package osc_pkg;
    // Direction of the dither triangle.
    typedef enum logic {
        TRI_UP = 1'b0,
        TRI_DN = 1'b1
    } tri_dir_e;
endpackage

// File: rtl/osc_tri_gen.sv
`timescale 1ns/1ps
// Symmetric triangle generator for period dithering.
// The value moves by one step on every (rate+1)-th step event, between -PEAK and +PEAK.
// Assumes step_evt is a single-clock pulse. The value is held at 0 while en is low.
module osc_tri_gen
    import osc_pkg::*;
#(
    parameter int TRI_PEAK = 16,
    parameter int RATE_W   = 8,
    parameter int TRI_W    = $clog2(TRI_PEAK + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic [RATE_W-1:0]        rate,
    input  logic                     step_evt,
    output logic signed [TRI_W-1:0]  tri_val
);
    localparam logic signed [TRI_W-1:0] PK  = TRI_W'(TRI_PEAK);
    localparam logic signed [TRI_W-1:0] NPK = -PK;
    localparam logic signed [TRI_W-1:0] ONE = TRI_W'(1);

    tri_dir_e          dir_q;
    logic [RATE_W-1:0] pre_q;

    // Prescale the step events, then move the triangle and turn it at the trip levels.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            tri_val <= '0;
            dir_q   <= TRI_UP;
            pre_q   <= '0;
        end else if (step_evt) begin
            if (pre_q == rate) begin
                pre_q <= '0;
                if (dir_q == TRI_UP) begin
                    tri_val <= tri_val + ONE;
                    if (tri_val + ONE == PK) dir_q <= TRI_DN;
                end else begin
                    tri_val <= tri_val - ONE;
                    if (tri_val - ONE == NPK) dir_q <= TRI_UP;
                end
            end else begin
                pre_q <= pre_q + RATE_W'(1);
            end
        end
    end
endmodule

// File: rtl/osc_period_calc.sv
`timescale 1ns/1ps
// Combinational period calculator.
// Computes nominal + floor(nominal*tri*depth / 2^OFF_SHIFT) and clamps the result to [PER_MIN, 2^CNT_W-1].
// Assumes PER_MIN fits in CNT_W bits.
module osc_period_calc #(
    parameter int CNT_W     = 16,
    parameter int TRI_W     = 6,
    parameter int DEPTH_W   = 4,
    parameter int DEPTH_MAX = 12,
    parameter int OFF_SHIFT = 11,
    parameter int PER_MIN   = 8
) (
    input  logic [CNT_W-1:0]        nom,
    input  logic signed [TRI_W-1:0] tri_val,
    input  logic [DEPTH_W-1:0]      depth,
    output logic [CNT_W-1:0]        per_next
);
    localparam int PROD_W = CNT_W + TRI_W + DEPTH_W + 2;
    localparam logic signed [PROD_W-1:0] LIM_LO = PROD_W'(PER_MIN);
    localparam logic signed [PROD_W-1:0] LIM_HI = PROD_W'((64'd1 << CNT_W) - 64'd1);

    logic [CNT_W-1:0]         nom_c;
    logic [DEPTH_W-1:0]       dep_c;
    logic signed [PROD_W-1:0] nom_s, tri_s, dep_s, prod, sum;

    // Apply the floors and the depth ceiling, form the offset and clamp the sum.
    always_comb begin
        nom_c = (nom < CNT_W'(PER_MIN)) ? CNT_W'(PER_MIN) : nom;
        dep_c = (depth > DEPTH_W'(DEPTH_MAX)) ? DEPTH_W'(DEPTH_MAX) : depth;
        nom_s = PROD_W'(nom_c);
        tri_s = PROD_W'(tri_val);
        dep_s = PROD_W'(dep_c);
        prod  = nom_s * tri_s * dep_s;
        sum   = nom_s + (prod >>> OFF_SHIFT);
        if (sum < LIM_LO)      per_next = CNT_W'(PER_MIN);
        else if (sum > LIM_HI) per_next = LIM_HI[CNT_W-1:0];
        else                   per_next = sum[CNT_W-1:0];
    end
endmodule

// File: rtl/osc_sync_qual.sv
`timescale 1ns/1ps
// Sync input qualifier.
// Synchronises the input, then emits one pulse on the SYNC_MIN-th consecutive high sample.
// Assumes sync_in is asynchronous to clk. A held level yields a single event.
module osc_sync_qual #(
    parameter int SYNC_MIN = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_evt
);
    localparam int RUN_W = $clog2(SYNC_MIN + 1);

    logic             s1_q, s2_q;
    logic [RUN_W-1:0] run_q;

    // Two-stage synchroniser and a saturating count of consecutive high samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            run_q <= '0;
        end else begin
            s1_q <= sync_in;
            s2_q <= s1_q;
            if (!s2_q)                          run_q <= '0;
            else if (run_q != RUN_W'(SYNC_MIN)) run_q <= run_q + RUN_W'(1);
        end
    end

    // Event on the sample that completes the minimum width.
    assign sync_evt = s2_q && (run_q == RUN_W'(SYNC_MIN - 1));
endmodule

// File: rtl/osc_dither_sync.sv
`timescale 1ns/1ps
// Switching-period generator with triangular dither and windowed external sync.
// Emits cyc_start at every cycle start and dmax_mark at the latest turn-off point.
// Assumes the synchronous active-low reset is held for at least two clocks.
module osc_dither_sync #(
    parameter int CNT_W     = 16,
    parameter int PER_MIN   = 8,
    parameter int TRI_PEAK  = 16,
    parameter int DEPTH_W   = 4,
    parameter int DEPTH_MAX = 12,
    parameter int OFF_SHIFT = 11,
    parameter int RATE_W    = 8,
    parameter int SYNC_MIN  = 10,
    parameter int FRAC_SH   = 5,
    parameter int WIN_LO    = 25,
    parameter int WIN_HI    = 29,
    parameter int DMAX_NUM  = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   period_nom,
    input  logic               dith_en,
    input  logic [DEPTH_W-1:0] dith_depth,
    input  logic [RATE_W-1:0]  dith_rate,
    input  logic               sync_in,
    output logic               cyc_start,
    output logic               dmax_mark
);
    localparam int TRI_W = $clog2(TRI_PEAK + 1) + 1;
    localparam int WIN_W = CNT_W + FRAC_SH + 2;
    localparam int DM_W  = CNT_W + FRAC_SH;

    logic [CNT_W-1:0]        cnt_q, per_q, per_next, dmax_pt;
    logic signed [TRI_W-1:0] tri_val;
    logic [WIN_W-1:0]        elapsed_sc, lo_lim, hi_lim;
    logic [DM_W-1:0]         dmax_full;
    logic                    sync_evt, sync_take, wrap, restart;

    osc_tri_gen #(
        .TRI_PEAK (TRI_PEAK),
        .RATE_W   (RATE_W),
        .TRI_W    (TRI_W)
    ) u_tri (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (dith_en),
        .rate     (dith_rate),
        .step_evt (restart),
        .tri_val  (tri_val)
    );

    osc_period_calc #(
        .CNT_W     (CNT_W),
        .TRI_W     (TRI_W),
        .DEPTH_W   (DEPTH_W),
        .DEPTH_MAX (DEPTH_MAX),
        .OFF_SHIFT (OFF_SHIFT),
        .PER_MIN   (PER_MIN)
    ) u_calc (
        .nom      (period_nom),
        .tri_val  (tri_val),
        .depth    (dith_depth),
        .per_next (per_next)
    );

    osc_sync_qual #(
        .SYNC_MIN (SYNC_MIN)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .sync_evt (sync_evt)
    );

    // Sync window test, turn-off point and restart decode.
    always_comb begin
        elapsed_sc = (WIN_W'(cnt_q) + WIN_W'(1)) << FRAC_SH;
        lo_lim     = WIN_W'(per_q) * WIN_W'(WIN_LO);
        hi_lim     = WIN_W'(per_q) * WIN_W'(WIN_HI);
        sync_take  = sync_evt && (elapsed_sc >= lo_lim) && (elapsed_sc <= hi_lim);
        wrap       = (cnt_q == per_q - CNT_W'(1));
        restart    = wrap || sync_take;
        dmax_full  = DM_W'(per_q) * DM_W'(DMAX_NUM);
        dmax_pt    = dmax_full[DM_W-1:FRAC_SH];
    end

    // Period counter, period latch and the two output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            per_q     <= per_next;
            cyc_start <= 1'b0;
            dmax_mark <= 1'b0;
        end else begin
            cnt_q     <= restart ? '0 : cnt_q + CNT_W'(1);
            if (restart) per_q <= per_next;
            cyc_start <= restart;
            dmax_mark <= !restart && (cnt_q + CNT_W'(1) == dmax_pt);
        end
    end
endmodule

// File: rtl/osc_dither_sync_chk.sv
`timescale 1ns/1ps
// Assertion checker for osc_dither_sync, attached by bind.
// Observes outputs and internal state of separate sub-blocks. It drives nothing.
module osc_dither_sync_chk #(
    parameter int CNT_W    = 16,
    parameter int PER_MIN  = 8,
    parameter int TRI_PEAK = 16,
    parameter int TRI_W    = 6
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cyc_start,
    input logic                    dmax_mark,
    input logic [CNT_W-1:0]        cnt,
    input logic [CNT_W-1:0]        per,
    input logic                    sync_take,
    input logic signed [TRI_W-1:0] tri_val
);
    logic signed [TRI_W-1:0] prev_tri;
    logic signed [TRI_W:0]   tri_diff;

    // Previous dither value, used for the step-size check.
    always_ff @(posedge clk) prev_tri <= tri_val;

    assign tri_diff = {tri_val[TRI_W-1], tri_val} - {prev_tri[TRI_W-1], prev_tri};

    // R2
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < per);

    // R5
    per_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per >= CNT_W'(PER_MIN));

    // R2
    lone_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !cyc_start);

    // R8
    wrap_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !$past(sync_take)) |-> ($past(cnt) == $past(per) - CNT_W'(1)));

    // R4
    tri_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_val <= TRI_W'(TRI_PEAK)) && (tri_val >= -TRI_W'(TRI_PEAK)));

    // R4
    tri_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_val != prev_tri) |-> ((tri_diff == 1) || (tri_diff == -1) || (tri_val == 0)));

    // R10
    dmax_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_start && dmax_mark));

    // R10
    dmax_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dmax_mark |-> ((cnt != '0) && (cnt < per)));
endmodule

bind osc_dither_sync osc_dither_sync_chk #(
    .CNT_W    (CNT_W),
    .PER_MIN  (PER_MIN),
    .TRI_PEAK (TRI_PEAK),
    .TRI_W    (TRI_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_start (cyc_start),
    .dmax_mark (dmax_mark),
    .cnt       (cnt_q),
    .per       (per_q),
    .sync_take (sync_take),
    .tri_val   (tri_val)
);

// File: tb/osc_dither_sync_tb.sv
`timescale 1ns/1ps
// Self-checking bench for osc_dither_sync.
module osc_dither_sync_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period_nom = 16'd100;
    logic        dith_en = 1'b0;
    logic [3:0]  dith_depth = 4'd0;
    logic [7:0]  dith_rate = 8'd0;
    logic        sync_in = 1'b0;
    logic        cyc_start, dmax_mark;
    int          checks = 0;
    int          errors = 0;

    osc_dither_sync u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_nom (period_nom),
        .dith_en    (dith_en),
        .dith_depth (dith_depth),
        .dith_rate  (dith_rate),
        .sync_in    (sync_in),
        .cyc_start  (cyc_start),
        .dmax_mark  (dmax_mark)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference period from the requirement formula.
    function automatic int model_period(input int nom, input int t, input int dep);
        int nc, dc, prod, sum;
        nc   = (nom < 8) ? 8 : nom;
        dc   = (dep > 12) ? 12 : dep;
        prod = nc * t * dc;
        sum  = nc + (prod >>> 11);
        if (sum < 8) sum = 8;
        if (sum > 65535) sum = 65535;
        return sum;
    endfunction

    function automatic int dmax_of(input int p);
        return (p * 23) >>> 5;
    endfunction

    task automatic do_reset(input int nom, input bit en, input int dep, input int rate);
        @(negedge clk);
        rst_n = 1'b0; sync_in = 1'b0;
        period_nom = 16'(nom); dith_en = en; dith_depth = 4'(dep); dith_rate = 8'(rate);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Counts clocks up to the next cyc_start and records where dmax_mark appeared.
    task automatic run_period(output int len, output int dpos);
        int n = 0;
        dpos = -1;
        do begin
            @(negedge clk); n++;
            if (dmax_mark) dpos = n;
        end while (!cyc_start && n < 70000);
        len = n;
    endtask

    // Same as run_period, but changes period_nom at clock 5 of the cycle.
    task automatic run_period_change(input int new_nom, output int len);
        int n = 0;
        do begin
            @(negedge clk); n++;
            if (n == 5) period_nom = 16'(new_nom);
        end while (!cyc_start && n < 70000);
        len = n;
    endtask

    // Raises sync_in at cycle count d for w clocks, then measures this cycle.
    task automatic sync_trial(input int d, input int w, input int p, input string tag);
        int n = 0, dpos = -1, e, exp_len;
        bit acc;
        do begin
            @(negedge clk); n++;
            if (n == d) sync_in = 1'b1;
            if (n == d + w) sync_in = 1'b0;
            if (dmax_mark) dpos = n;
        end while (!cyc_start && n < 70000);
        sync_in = 1'b0;
        e   = d + 12;
        acc = (w >= 10) && (32 * e >= 25 * p) && (32 * e <= 29 * p) && (e < p);
        exp_len = acc ? e : p;
        check(n == exp_len, $sformatf("%s d=%0d w=%0d", tag, d, w), n, exp_len);
        check(dpos == dmax_of(p), "R10 marker in sync trial", dpos, dmax_of(p));
    endtask

    // Dithered run checked against the triangle and period model.
    task automatic dither_run(input int nom, input int dep, input int rate, input int nper, input string tag);
        int t = 0, up = 1, rc = 0, p, len, dpos;
        do_reset(nom, 1'b1, dep, rate);
        p = model_period(nom, 0, dep);
        for (int k = 0; k < nper; k++) begin
            run_period(len, dpos);
            check(len == p, $sformatf("%s R4 R5 period %0d", tag, k), len, p);
            check(dpos == dmax_of(p), "R10 marker under dither", dpos, dmax_of(p));
            p = model_period(nom, t, dep);
            if (rc == rate) begin
                rc = 0;
                if (up == 1) begin t++; if (t == 16) up = 0; end
                else begin t--; if (t == -16) up = 1; end
            end else rc++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int len, dpos, s;
        s = $urandom(32'd20240);

        // R1: reset state and first cycle start.
        do_reset(100, 1'b0, 0, 0);
        check(!cyc_start && !dmax_mark, "R1 outputs low at release", {cyc_start, dmax_mark}, 0);
        run_period(len, dpos);
        check(len == 100, "R1 first pulse after reset", len, 100);

        // R2 and R10: free-running without dither.
        for (int k = 0; k < 3; k++) begin
            run_period(len, dpos);
            check(len == 100, "R2 free-run period", len, 100);
            check(dpos == 71, "R10 marker position", dpos, 71);
        end

        // R5: floor on a tiny nominal count.
        do_reset(3, 1'b0, 0, 0);
        for (int k = 0; k < 3; k++) begin
            run_period(len, dpos);
            check(len == 8, "R5 period floor", len, 8);
            check(dpos == 5, "R10 marker at floor", dpos, 5);
        end

        // R3: a mid-cycle change applies from the next cycle.
        do_reset(120, 1'b0, 0, 0);
        run_period(len, dpos);
        run_period_change(90, len);
        check(len == 120, "R3 current cycle unchanged", len, 120);
        run_period(len, dpos);
        check(len == 90, "R3 new period next cycle", len, 90);

        // R4 R5 R6: directed full triangle with saturated depth, plus the floor under dither.
        dither_run(200, 15, 0, 70, "R6 depth saturation");
        dither_run(8, 12, 0, 20, "R5 clamp under dither");
        dither_run(300, 7, 2, 30, "R4 slow step");
        for (int r = 0; r < 4; r++)
            dither_run($urandom_range(300, 50), $urandom_range(15, 0),
                       $urandom_range(3, 0), 36, "R4 random");

        // R7 R8 R9: sync width and window, directed and then random.
        do_reset(100, 1'b0, 0, 0);
        run_period(len, dpos);
        sync_trial(67, 11, 100, "R9 lower window edge");
        sync_trial(66, 11, 100, "R9 below window");
        sync_trial(78, 11, 100, "R9 upper window edge");
        sync_trial(79, 11, 100, "R9 above window");
        sync_trial(70, 9, 100, "R7 short pulse ignored");
        sync_trial(70, 10, 100, "R7 R8 minimum width");
        run_period(len, dpos);
        check(len == 100, "R8 free-run after sync", len, 100);
        for (int k = 0; k < 24; k++)
            sync_trial($urandom_range(85, 10), $urandom_range(12, 8), 100, "R8 R9 random");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule